// File: doc/BRIEF.md
# SD Command Line Transceiver

This block connects a host controller to the one-bit, bidirectional command line of an SD card. The controller presents a 6-bit command index and a 32-bit argument with a one-cycle strobe. The block then drives a 48-bit command token onto the line, one bit per clock, with its CRC7 computed in hardware. When the token has gone out, the block releases the line and waits for the card to answer on the same wire.

A short answer is 48 bits long. The block returns its index and argument. A long answer is 136 bits long and carries the card's identification record. The block splits that record into named fields: manufacturer, OEM, product name, revision, serial number and date. Two flags are captured with each command. One selects a long answer. The other selects whether a CRC mismatch in the answer counts as an error, which the controller clears for the operating-conditions answer, since that answer carries no valid CRC.

An acknowledge pulse comes one bit time before the end bit, so the controller can prepare its next step early. A missing answer ends in a timeout error. The clock is the line's bit clock.

Top module: `sdcmd_xcvr`

## Requirements
- R1: A command token is 48 consecutive bits, one per clock, MSB first: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, the 7-bit CRC and a 1 end bit.
- R2: The CRC7 uses the polynomial x^7 + x^3 + 1, starts from zero and covers the first 40 token bits. Index 0 with argument 0 gives CRC 7'h4A, so the token is 48'h400000000095.
- R3: `ack` is a one-cycle pulse. It is high in the cycle in which the last CRC bit is on the line, which is the cycle just before the end bit.
- R4: `cmd_oe` is high for exactly the 48 token cycles. Whenever it is low, `cmd_out` is 1.
- R5: After the line is released, the first 0 sampled on `cmd_in` starts a response. A short response holds a start bit, a direction bit, the index, the argument, the CRC over its first 40 bits, and an end bit. When it is accepted, `rsp_valid` pulses for one cycle and `rsp_index`/`rsp_arg` carry the received index and argument.
- R6: If `expect_long` was high when the command was accepted, the response is 136 bits long: start, direction, six reserved bits, and 128 record bits numbered 127 down to 0. CRC7 over record bits 127:8 must equal bits 7:1. On acceptance the block sets the outputs as follows: `id_mfr` = 127:120, `id_oem` = 119:104, `id_name` = 103:64, `id_rev` = 63:56, `id_serial` = 55:24, `id_date` = 19:8.
- R7: If `check_crc` was high at acceptance and the received CRC does not match, `rsp_err` pulses instead of `rsp_valid`. The index, argument and record outputs keep their previous values.
- R8: If `check_crc` was low at acceptance, a CRC mismatch is ignored and the response is delivered with `rsp_valid`.
- R9: `receiving` rises on the clock edge that samples the start bit and falls on the edge that samples the end bit, the same edge that raises `rsp_valid` or `rsp_err`.
- R10: If no 0 is seen in the TIMEOUT (64) samples that follow the release of the line, `rsp_err` and `rsp_timeout` pulse together. A start bit in the 64th sample is still accepted.
- R11: `cmd_valid` is ignored while a token is being sent or its response is awaited or received.
- R12: After reset, `cmd_oe`, `ack`, `receiving`, `rsp_valid`, `rsp_err` and `rsp_timeout` are 0, and `cmd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when the block is idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| expect_long | input | 1 | The response to this command is the 136-bit record |
| check_crc | input | 1 | A response CRC mismatch is reported as an error |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Value driven onto the line |
| cmd_oe | output | 1 | Line driver enable |
| ack | output | 1 | Last CRC bit is on the line |
| receiving | output | 1 | A response is being shifted in |
| rsp_valid | output | 1 | A response was accepted |
| rsp_err | output | 1 | CRC failure or timeout |
| rsp_timeout | output | 1 | No response started in time |
| rsp_index | output | 6 | Index of the last accepted short response |
| rsp_arg | output | 32 | Argument of the last accepted short response |
| id_mfr | output | 8 | Manufacturer id |
| id_oem | output | 16 | OEM id |
| id_name | output | 40 | Product name |
| id_rev | output | 8 | Product revision |
| id_serial | output | 32 | Serial number |
| id_date | output | 12 | Manufacturing date |

## Verification
The hardest case to reach from the ports is the edge of the response window. The start bit must land exactly in the last sample that may still begin a response, or exactly in the first sample. The bench's card model waits for the negedge at which it first sees `cmd_oe` low. It then counts a chosen number of further negedges before driving the start bit, so that the start bit is placed in sample 1 or sample 64. A silent card covers sample 65. A second command is pulsed in the middle of a token to show that the block drops it. CRC faults are injected by flipping one CRC bit of a response while `check_crc` is either set or clear.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int IDX_W  = 6;
  localparam int ARG_W  = 32;
  localparam int CRC_W  = 7;
  localparam int BODY_W = 2 + IDX_W + ARG_W;          // start..argument
  localparam int TOK_W  = BODY_W + CRC_W + 1;         // short token
  localparam int CID_W  = 128;
  localparam int LONG_W = 2 + 6 + CID_W;              // long response
  localparam int CID_CRC_LO = 8;                      // CRC covers record 127:8

  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;      // x^7 + x^3 + 1

  typedef enum logic [1:0] {RX_OFF, RX_HUNT, RX_SHIFT} rx_state_e;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_body(input logic [BODY_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc7_step(crc, din);
  end
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BODY_W-1:0] body,
  output logic              line_out,
  output logic              line_oe,
  output logic              ack,
  output logic              busy,
  output logic              finish
);
  localparam int CNT_W = $clog2(TOK_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TOK_W - 1);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(2);

  logic [TOK_W-2:0] sr;
  logic [CNT_W-1:0] cnt;

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b1;
      line_oe  <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      sr       <= '0;
      ack      <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (!busy) begin
        if (start) begin
          line_out <= body[BODY_W-1];
          line_oe  <= 1'b1;
          busy     <= 1'b1;
          cnt      <= CNT_LOAD;
          sr       <= {body[BODY_W-2:0], crc7_body(body), 1'b1};
        end
      end else if (cnt == '0) begin
        line_out <= 1'b1;
        line_oe  <= 1'b0;
        busy     <= 1'b0;
      end else begin
        line_out <= sr[TOK_W-2];
        sr       <= {sr[TOK_W-3:0], 1'b0};
        cnt      <= cnt - 1'b1;
        ack      <= (cnt == CNT_ACK);
      end
    end
  end
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             long_mode,
  input  logic             check_en,
  input  logic             line_in,
  output logic             idle,
  output logic             receiving,
  output logic             valid,
  output logic             err,
  output logic             timeout,
  output logic [IDX_W-1:0] index,
  output logic [ARG_W-1:0] arg,
  output logic [7:0]       mfr,
  output logic [15:0]      oem,
  output logic [39:0]      name,
  output logic [7:0]       rev,
  output logic [31:0]      serial,
  output logic [11:0]      date
);
  localparam int POS_W = $clog2(LONG_W);
  localparam int WC_W  = $clog2(TIMEOUT + 1);
  localparam logic [POS_W-1:0] LAST_S   = POS_W'(TOK_W - 1);
  localparam logic [POS_W-1:0] LAST_L   = POS_W'(LONG_W - 1);
  localparam logic [POS_W-1:0] S_CRC_HI = POS_W'(BODY_W - 1);
  localparam logic [POS_W-1:0] L_CRC_LO = POS_W'(LONG_W - 1 - (CID_W - 1));
  localparam logic [POS_W-1:0] L_CRC_HI = POS_W'(LONG_W - 1 - CID_CRC_LO);
  localparam logic [WC_W-1:0]  WC_LAST  = WC_W'(TIMEOUT - 1);

  rx_state_e        st;
  logic [WC_W-1:0]  wcnt;
  logic [POS_W-1:0] pos;
  logic [CID_W-1:0] sr;
  logic [POS_W-1:0] last_pos;
  logic             crc_en, crc_clr, crc_bad;
  logic [CRC_W-1:0] crc;

  assign idle     = (st == RX_OFF);
  assign last_pos = long_mode ? LAST_L : LAST_S;
  assign crc_clr  = (st == RX_HUNT) && !line_in;
  assign crc_en   = (st == RX_SHIFT) && (pos != last_pos) &&
                    (long_mode ? (pos >= L_CRC_LO && pos <= L_CRC_HI) : (pos <= S_CRC_HI));
  assign crc_bad  = (crc != sr[CRC_W-1:0]);

  sdcmd_crc7 u_crc (
    .clk (clk), .rst (rst), .clr (crc_clr), .en (crc_en), .din (line_in), .crc (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_OFF;  wcnt <= '0;  pos <= '0;  sr <= '0;
      receiving <= 1'b0;  valid <= 1'b0;  err <= 1'b0;  timeout <= 1'b0;
      index <= '0;  arg <= '0;
      mfr <= '0;  oem <= '0;  name <= '0;  rev <= '0;  serial <= '0;  date <= '0;
    end else begin
      valid   <= 1'b0;
      err     <= 1'b0;
      timeout <= 1'b0;
      case (st)
        RX_OFF: if (arm) begin
          st   <= RX_HUNT;
          wcnt <= '0;
        end
        RX_HUNT: begin
          if (!line_in) begin
            st        <= RX_SHIFT;
            pos       <= POS_W'(1);
            receiving <= 1'b1;
          end else if (wcnt == WC_LAST) begin
            st      <= RX_OFF;
            err     <= 1'b1;
            timeout <= 1'b1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        RX_SHIFT: begin
          if (pos == last_pos) begin
            st        <= RX_OFF;
            receiving <= 1'b0;
            if (check_en && crc_bad) begin
              err <= 1'b1;
            end else begin
              valid <= 1'b1;
              if (long_mode) begin
                mfr    <= sr[126 -: 8];
                oem    <= sr[118 -: 16];
                name   <= sr[102 -: 40];
                rev    <= sr[62 -: 8];
                serial <= sr[54 -: 32];
                date   <= sr[18 -: 12];
              end else begin
                index <= sr[CRC_W+ARG_W +: IDX_W];
                arg   <= sr[CRC_W +: ARG_W];
              end
            end
          end else begin
            sr  <= {sr[CID_W-2:0], line_in};
            pos <= pos + 1'b1;
          end
        end
        default: st <= RX_OFF;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_xcvr.sv
module sdcmd_xcvr
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             expect_long,
  input  logic             check_crc,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             ack,
  output logic             receiving,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             rsp_timeout,
  output logic [IDX_W-1:0] rsp_index,
  output logic [ARG_W-1:0] rsp_arg,
  output logic [7:0]       id_mfr,
  output logic [15:0]      id_oem,
  output logic [39:0]      id_name,
  output logic [7:0]       id_rev,
  output logic [31:0]      id_serial,
  output logic [11:0]      id_date
);
  logic tx_busy, tx_finish, rx_idle, accept;
  logic long_q, chk_q;
  logic [BODY_W-1:0] body;

  assign accept = cmd_valid && !tx_busy && rx_idle;
  assign body   = {1'b0, 1'b1, cmd_index, cmd_arg};

  always_ff @(posedge clk) begin
    if (rst) begin
      long_q <= 1'b0;
      chk_q  <= 1'b1;
    end else if (accept) begin
      long_q <= expect_long;
      chk_q  <= check_crc;
    end
  end

  sdcmd_tx u_tx (
    .clk (clk), .rst (rst), .start (accept), .body (body),
    .line_out (cmd_out), .line_oe (cmd_oe), .ack (ack),
    .busy (tx_busy), .finish (tx_finish)
  );

  sdcmd_rx #(.TIMEOUT(TIMEOUT)) u_rx (
    .clk (clk), .rst (rst), .arm (tx_finish), .long_mode (long_q),
    .check_en (chk_q), .line_in (cmd_in), .idle (rx_idle),
    .receiving (receiving), .valid (rsp_valid), .err (rsp_err),
    .timeout (rsp_timeout), .index (rsp_index), .arg (rsp_arg),
    .mfr (id_mfr), .oem (id_oem), .name (id_name), .rev (id_rev),
    .serial (id_serial), .date (id_date)
  );
endmodule

// File: rtl/sdcmd_xcvr_chk.sv
module sdcmd_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic cmd_out,
  input logic cmd_oe,
  input logic ack,
  input logic receiving,
  input logic rsp_valid,
  input logic rsp_err,
  input logic rsp_timeout
);
  p_start_bit_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_oe) |-> !cmd_out);
  p_ack_before_end_r3: assert property (@(posedge clk) disable iff (rst)
    ack |=> (cmd_oe && cmd_out));
  p_ack_single_r3: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  p_idle_line_high_r4: assert property (@(posedge clk) disable iff (rst)
    !cmd_oe |-> cmd_out);
  p_valid_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_err));
  p_recv_ends_with_result_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(receiving) |-> (rsp_valid || rsp_err));
  p_timeout_is_err_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_timeout |-> (rsp_err && !receiving));
  p_no_drive_while_recv_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> !receiving);
endmodule

bind sdcmd_xcvr sdcmd_xcvr_chk u_chk (
  .clk (clk), .rst (rst), .cmd_out (cmd_out), .cmd_oe (cmd_oe), .ack (ack),
  .receiving (receiving), .rsp_valid (rsp_valid), .rsp_err (rsp_err),
  .rsp_timeout (rsp_timeout)
);

// File: tb/sdcmd_xcvr_test.sv
module sdcmd_xcvr_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic expect_long = 1'b0;
  logic check_crc = 1'b1;
  logic cmd_in = 1'b1;
  logic cmd_out, cmd_oe, ack, receiving, rsp_valid, rsp_err, rsp_timeout;
  logic [5:0] rsp_index;
  logic [31:0] rsp_arg;
  logic [7:0] id_mfr, id_rev;
  logic [15:0] id_oem;
  logic [39:0] id_name;
  logic [31:0] id_serial;
  logic [11:0] id_date;

  always #5 clk = ~clk;

  sdcmd_xcvr uut (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_index (cmd_index),
    .cmd_arg (cmd_arg), .expect_long (expect_long), .check_crc (check_crc),
    .cmd_in (cmd_in), .cmd_out (cmd_out), .cmd_oe (cmd_oe), .ack (ack),
    .receiving (receiving), .rsp_valid (rsp_valid), .rsp_err (rsp_err),
    .rsp_timeout (rsp_timeout), .rsp_index (rsp_index), .rsp_arg (rsp_arg),
    .id_mfr (id_mfr), .id_oem (id_oem), .id_name (id_name), .id_rev (id_rev),
    .id_serial (id_serial), .id_date (id_date)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct packed {
    logic         to;
    logic         err;
    logic         val;
    logic         lng;
    logic [5:0]   idx;
    logic [31:0]  arg;
    logic [127:0] cid;
  } rsp_t;

  logic [47:0] tx_q[$];
  rsp_t        rsp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // CRC7 x^7+x^3+1, zero start, over d[n-1:0] MSB first
  function automatic logic [6:0] ref_crc(input logic [127:0] d, input int n);
    logic [6:0] r;
    logic top;
    r = 7'd0;
    for (int i = n - 1; i >= 0; i--) begin
      top = r[6] ^ d[i];
      r = r << 1;
      if (top) r = r ^ 7'b0001001;
    end
    return r;
  endfunction

  function automatic logic [47:0] ref_token(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] b;
    b = {2'b01, idx, arg};
    return {b, ref_crc({88'd0, b}, 40), 1'b1};
  endfunction

  // ---------------- transmit monitor (R1, R3, R4, R11) ----------------
  logic [47:0] tok_sh = '0;
  int tok_n = 0, ack_at = 0, ack_n = 0;
  bit prev_oe = 0;
  always @(negedge clk) if (!rst) begin
    if (cmd_oe) begin
      tok_sh = {tok_sh[46:0], cmd_out};
      tok_n++;
      if (ack) begin ack_at = tok_n; ack_n++; end
    end else if (prev_oe) begin
      if (tx_q.size() == 0) chk(0, "R11 unexpected token", {80'd0, tok_sh}, 0);
      else begin
        logic [47:0] e;
        e = tx_q.pop_front();
        chk(tok_sh == e, "R1 token bits", {80'd0, tok_sh}, {80'd0, e});
      end
      chk(tok_n == 48, "R4 driver enable length", tok_n, 48);
      chk(ack_n == 1 && ack_at == 47, "R3 acknowledge position", ack_at, 47);
      tok_n = 0; ack_n = 0; ack_at = 0;
    end
    prev_oe = cmd_oe;
  end

  // ---------------- response monitor (R5..R8, R10) ----------------
  always @(negedge clk) if (!rst && (rsp_valid || rsp_err || rsp_timeout)) begin
    if (rsp_q.size() == 0) chk(0, "R5 unexpected response", 0, 0);
    else begin
      rsp_t e;
      e = rsp_q.pop_front();
      chk(rsp_timeout == e.to, "R10 timeout flag", rsp_timeout, e.to);
      chk(rsp_err == e.err, "R7 error flag", rsp_err, e.err);
      chk(rsp_valid == e.val, "R8 valid flag", rsp_valid, e.val);
      if (e.val && !e.lng) begin
        chk(rsp_index == e.idx, "R5 response index", rsp_index, e.idx);
        chk(rsp_arg == e.arg, "R5 response argument", rsp_arg, e.arg);
      end
      if (e.val && e.lng) begin
        chk(id_mfr == e.cid[127:120], "R6 manufacturer", id_mfr, e.cid[127:120]);
        chk(id_oem == e.cid[119:104], "R6 oem", id_oem, e.cid[119:104]);
        chk(id_name == e.cid[103:64], "R6 name", id_name, e.cid[103:64]);
        chk(id_rev == e.cid[63:56], "R6 revision", id_rev, e.cid[63:56]);
        chk(id_serial == e.cid[55:24], "R6 serial", id_serial, e.cid[55:24]);
        chk(id_date == e.cid[19:8], "R6 date", id_date, e.cid[19:8]);
      end
    end
  end

  task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg,
                          input bit lng, input bit crc_on);
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; expect_long = lng; check_crc = crc_on;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // card model: waits for release, then 'gap' negedges, then drives bits
  task automatic card(input logic [135:0] bits, input int len, input int gap);
    int bad_recv;
    bad_recv = 0;
    do @(negedge clk); while (!cmd_oe);
    do @(negedge clk); while (cmd_oe);
    repeat (gap) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = bits[i];
      if (i != len - 1 && !receiving) bad_recv++;
      @(negedge clk);
    end
    cmd_in = 1'b1;
    chk(bad_recv == 0, "R9 receiving held during response", bad_recv, 0);
    chk(!receiving, "R9 receiving low after end bit", receiving, 0);
  endtask

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] arg, input bit bad);
    logic [39:0] b;
    logic [6:0] c;
    b = {2'b00, idx, arg};
    c = ref_crc({88'd0, b}, 40) ^ {6'd0, bad};
    return {88'd0, b, c, 1'b1};
  endfunction

  function automatic logic [127:0] make_cid(input logic [127:0] raw, input bit bad);
    logic [127:0] c;
    c = raw;
    c[7:1] = ref_crc(raw >> 8, 120) ^ {6'd0, bad};
    c[0] = 1'b1;
    return c;
  endfunction

  task automatic expect_rsp(input bit to, input bit err, input bit val, input bit lng,
                            input logic [5:0] idx, input logic [31:0] arg, input logic [127:0] cid);
    rsp_t e;
    e.to = to; e.err = err; e.val = val; e.lng = lng; e.idx = idx; e.arg = arg; e.cid = cid;
    rsp_q.push_back(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    logic [127:0] cid;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!cmd_oe && cmd_out, "R12 line released after reset", {cmd_oe, cmd_out}, 2'b01);
    chk(!ack && !receiving, "R12 ack/receiving low", {ack, receiving}, 0);
    chk(!rsp_valid && !rsp_err && !rsp_timeout, "R12 result flags low",
        {rsp_valid, rsp_err, rsp_timeout}, 0);

    // R2 known vector, R5 short response
    tx_q.push_back(48'h400000000095);
    send_cmd(6'd0, 32'd0, 0, 1);
    expect_rsp(0, 0, 1, 0, 6'd8, 32'h000001AA, 0);
    card(short_rsp(6'd8, 32'h000001AA, 0), 48, 3);
    repeat (3) @(negedge clk);

    // R7 CRC failure with checking on: outputs held
    tx_q.push_back(ref_token(6'd55, 32'h12340000));
    send_cmd(6'd55, 32'h12340000, 0, 1);
    expect_rsp(0, 1, 0, 0, 0, 0, 0);
    card(short_rsp(6'd55, 32'h00000120, 1), 48, 2);
    @(negedge clk);
    chk(rsp_index == 6'd8 && rsp_arg == 32'h1AA, "R7 outputs kept after error",
        {rsp_index, rsp_arg}, {6'd8, 32'h1AA});
    repeat (2) @(negedge clk);

    // R8 CRC mismatch ignored when checking is off
    tx_q.push_back(ref_token(6'd41, 32'h40FF8000));
    send_cmd(6'd41, 32'h40FF8000, 0, 0);
    expect_rsp(0, 0, 1, 0, 6'h3F, 32'h80FF8000, 0);
    card(short_rsp(6'h3F, 32'h80FF8000, 1), 48, 5);
    repeat (3) @(negedge clk);

    // R6 long response decoded into fields
    cid = make_cid({8'hA5, 16'h3C5A, 40'h1122334455, 8'h61, 32'hDEADBEEF, 4'h0, 12'h9C3, 8'h00}, 0);
    tx_q.push_back(ref_token(6'd2, 32'd0));
    send_cmd(6'd2, 32'd0, 1, 1);
    expect_rsp(0, 0, 1, 1, 0, 0, cid);
    card({2'b00, 6'h3F, cid}, 136, 4);
    repeat (3) @(negedge clk);

    // R6/R7 long response with bad CRC
    cid = make_cid({8'h5A, 16'hC3A5, 40'h99AABBCCDD, 8'h17, 32'h01234567, 4'h0, 12'h123, 8'h00}, 1);
    tx_q.push_back(ref_token(6'd2, 32'd0));
    send_cmd(6'd2, 32'd0, 1, 1);
    expect_rsp(0, 1, 0, 1, 0, 0, 0);
    card({2'b00, 6'h3F, cid}, 136, 1);
    @(negedge clk);
    chk(id_mfr == 8'hA5 && id_serial == 32'hDEADBEEF, "R7 record kept after error",
        {id_mfr, id_serial}, {8'hA5, 32'hDEADBEEF});
    repeat (2) @(negedge clk);

    // R10 silent card times out
    tx_q.push_back(ref_token(6'd13, 32'hABCD0000));
    send_cmd(6'd13, 32'hABCD0000, 0, 1);
    expect_rsp(1, 1, 0, 0, 0, 0, 0);
    do @(negedge clk); while (!(rsp_valid || rsp_err));
    repeat (3) @(negedge clk);

    // R10 start bit in the last allowed sample
    tx_q.push_back(ref_token(6'd13, 32'h00070000));
    send_cmd(6'd13, 32'h00070000, 0, 1);
    expect_rsp(0, 0, 1, 0, 6'd13, 32'h00000900, 0);
    card(short_rsp(6'd13, 32'h00000900, 0), 48, 63);
    repeat (3) @(negedge clk);

    // R11 a strobe in mid-token is dropped; start in first sample
    tx_q.push_back(ref_token(6'd17, 32'h00000200));
    send_cmd(6'd17, 32'h00000200, 0, 1);
    repeat (5) @(negedge clk);
    cmd_index = 6'd24; cmd_arg = 32'hFFFF0000; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    expect_rsp(0, 0, 1, 0, 6'd17, 32'h00000B00, 0);
    card(short_rsp(6'd17, 32'h00000B00, 0), 48, 0);
    repeat (80) @(negedge clk);
    chk(tx_q.size() == 0 && rsp_q.size() == 0, "R11 no extra token or response",
        tx_q.size() + rsp_q.size(), 0);
    chk(!cmd_oe && cmd_out, "R4 line idle after all exchanges", {cmd_oe, cmd_out}, 2'b01);

    done = 1;
    summary();
  end
endmodule